// File: doc/BRIEF.md
# Multi-channel configurable CRC engine

This block is a register-mapped CRC accelerator with eight channels that never share state. Every channel keeps its own generator polynomial, start value, final XOR mask, CRC width (1 to 32 bits) and three ordering controls: bit reflection of each input byte, bit reflection of the result, and reversal of the byte order of each input word. Software sets a channel up either field by field or by writing a small algorithm code that loads a complete standard algorithm from a built-in catalogue.

After setup, software writes 32-bit words to the channel's data register. The channel folds all four bytes into its running state on the clock edge that takes the write. Reading the result register returns the finished CRC. The bus is a plain synchronous register port with an address, a write strobe, write data and read data. Read data is combinational from the addressed register.

Top module: `crc_mc_engine`

## Requirements
- R1: Channel n owns the 64-byte window that starts at n*0x40. Word offsets within a window are: algorithm code 0x00, clear 0x04, polynomial 0x08, start value 0x0C, final XOR 0x10, mode 0x14, data 0x18, result 0x1C. Offsets 0x20 to 0x3F read 0 and ignore writes. An access whose address bits 1:0 are nonzero reads 0 and writes nothing.
- R2: The polynomial, start value, final XOR and data registers are 32 bits wide and read back the last value written, starting with the cycle after the write.
- R3: Writing a word with bit 0 set to the clear register sets that channel's algorithm code, polynomial, start value, final XOR, mode, data and running state to 0. A clear write with bit 0 low changes nothing. The clear register always reads 0.
- R4: The mode register holds the width in bits 5:0, input byte bit reflection in bit 8, result bit reflection in bit 16 and input word byte reversal in bit 24. All other bits read 0.
- R5: Writing an algorithm code to bits 7:0 stores the code, and the code reads back in bits 7:0. Codes 1 to 15 also load polynomial, start value, final XOR, width and both reflection flags from the catalogue, and load the running state with the start value. The byte reversal flag is kept. The catalogue, in code order, is CRC32, CRC32-AUTOSAR, CRC16-CCITT (reflected, start 0), CRC16-XMODEM, CRC16-MODBUS, CRC16-DNP, CRC16-X25, CRC16-USB, CRC16-MAXIM, CRC16-IBM, CRC8-MAXIM, CRC8-ROHC, CRC8-ITU, CRC8 and CRC5-USB. Code 0 and codes 16 to 255 change nothing else.
- R6: A data write folds four bytes into the state in one clock. The word's byte order is reversed first if byte reversal is set. The bytes are then taken least-significant first. Each byte enters the shift register most-significant bit first, or least-significant bit first when input reflection is set.
- R7: The result reads as the state masked to the width, bit-reversed within the width when result reflection is set, then XORed with the final XOR mask and masked to the width. Bits above the width read 0.
- R8: Writing the start value register, or writing the result register, loads the running state with the written value masked to the width.
- R9: A width field of 0 or above 32 acts as a width of 32.
- R10: A write to one channel leaves every register of every other channel unchanged.
- R11: After a synchronous active-low reset, every register of every channel reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 9 | Byte address: channel in bits 8:6, offset in bits 5:0 |
| reg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register, combinational |

## Verification
Every register write, including a full four-byte data fold, takes effect on the first rising edge that sees the strobe. The new value therefore appears on the read port in the very next cycle, and read data follows the address in the same cycle. The bench drives the bus at the falling edge and compares the read port two nanoseconds later against a behavioural model, once in every cycle. The model is updated one nanosecond after the rising edge, so the value it predicts for each cycle already includes any write taken on that edge.

// File: rtl/crc_mc_pkg.sv
// crc_mc_pkg: shared constants, the algorithm record and the helper functions
// of the multi-channel CRC engine. It assumes a 32-bit data path and CRC
// widths from 1 to 32 bits.
package crc_mc_pkg;

    localparam int CRC_DW   = 32;
    localparam int BYTE_W   = 8;
    localparam int WIDTH_FW = 6;

    // word offsets inside a channel window (address bits 5:2)
    localparam logic [3:0] WOFF_CODE   = 4'd0;
    localparam logic [3:0] WOFF_CLEAR  = 4'd1;
    localparam logic [3:0] WOFF_POLY   = 4'd2;
    localparam logic [3:0] WOFF_START  = 4'd3;
    localparam logic [3:0] WOFF_FXOR   = 4'd4;
    localparam logic [3:0] WOFF_MODE   = 4'd5;
    localparam logic [3:0] WOFF_DATA   = 4'd6;
    localparam logic [3:0] WOFF_RESULT = 4'd7;

    // mode register bit positions
    localparam int MODE_REFIN_BIT  = 8;
    localparam int MODE_REFOUT_BIT = 16;
    localparam int MODE_BREV_BIT   = 24;

    typedef struct packed {
        logic [CRC_DW-1:0]   poly;
        logic [CRC_DW-1:0]   start;
        logic [CRC_DW-1:0]   fxor;
        logic [WIDTH_FW-1:0] width;
        logic                ref_in;
        logic                ref_out;
    } crc_algo_t;

    // bit reversal of a full word
    function automatic logic [CRC_DW-1:0] flip_word(input logic [CRC_DW-1:0] x);
        logic [CRC_DW-1:0] r;
        for (int i = 0; i < CRC_DW; i++) r[i] = x[CRC_DW-1-i];
        return r;
    endfunction

    // bit reversal of one byte
    function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] x);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = x[BYTE_W-1-i];
        return r;
    endfunction

    // width field to effective width: 0 and anything above 32 mean 32
    function automatic logic [WIDTH_FW-1:0] eff_width(input logic [WIDTH_FW-1:0] w);
        return (w == '0 || w > WIDTH_FW'(CRC_DW)) ? WIDTH_FW'(CRC_DW) : w;
    endfunction

    // low-order mask of an effective width (1..32)
    function automatic logic [CRC_DW-1:0] width_mask(input logic [WIDTH_FW-1:0] ew);
        logic [CRC_DW:0] wide;
        wide = ({{CRC_DW{1'b0}}, 1'b1} << ew) - 1'b1;
        return wide[CRC_DW-1:0];
    endfunction

    // catalogue membership of an algorithm code
    function automatic logic code_known(input logic [7:0] code);
        return (code >= 8'd1) && (code <= 8'd15);
    endfunction

    // catalogue of standard algorithms, indexed by code
    function automatic crc_algo_t code_lookup(input logic [7:0] code);
        crc_algo_t a;
        a = '{poly: '0, start: '0, fxor: '0, width: '0, ref_in: 1'b0, ref_out: 1'b0};
        case (code)
            8'd1:  a = '{32'h04C11DB7, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd32, 1'b1, 1'b1};
            8'd2:  a = '{32'hF4ACFB13, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd32, 1'b1, 1'b1};
            8'd3:  a = '{32'h00001021, 32'h00000000, 32'h00000000, 6'd16, 1'b1, 1'b1};
            8'd4:  a = '{32'h00001021, 32'h00000000, 32'h00000000, 6'd16, 1'b0, 1'b0};
            8'd5:  a = '{32'h00008005, 32'h0000FFFF, 32'h00000000, 6'd16, 1'b1, 1'b1};
            8'd6:  a = '{32'h00003D65, 32'h00000000, 32'h0000FFFF, 6'd16, 1'b1, 1'b1};
            8'd7:  a = '{32'h00001021, 32'h0000FFFF, 32'h0000FFFF, 6'd16, 1'b1, 1'b1};
            8'd8:  a = '{32'h00008005, 32'h0000FFFF, 32'h0000FFFF, 6'd16, 1'b1, 1'b1};
            8'd9:  a = '{32'h00008005, 32'h00000000, 32'h0000FFFF, 6'd16, 1'b1, 1'b1};
            8'd10: a = '{32'h00008005, 32'h00000000, 32'h00000000, 6'd16, 1'b1, 1'b1};
            8'd11: a = '{32'h00000031, 32'h00000000, 32'h00000000, 6'd8,  1'b1, 1'b1};
            8'd12: a = '{32'h00000007, 32'h000000FF, 32'h00000000, 6'd8,  1'b1, 1'b1};
            8'd13: a = '{32'h00000007, 32'h00000000, 32'h00000055, 6'd8,  1'b0, 1'b0};
            8'd14: a = '{32'h00000007, 32'h00000000, 32'h00000000, 6'd8,  1'b0, 1'b0};
            8'd15: a = '{32'h00000005, 32'h0000001F, 32'h0000001F, 6'd5,  1'b1, 1'b1};
            default: ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/crc_word_folder.sv
// crc_word_folder: combinational fold of one data word into a CRC state.
// The state is held right-aligned in CRC_DW bits; here it is shifted up so
// that its top bit sits at bit CRC_DW-1, which lets one shift structure serve
// every width. Assumes ew is already an effective width (1..CRC_DW).
module crc_word_folder
    import crc_mc_pkg::*;
#(
    parameter int NUM_BYTES = 4
) (
    input  logic [CRC_DW-1:0]   state,
    input  logic [CRC_DW-1:0]   poly,
    input  logic [WIDTH_FW-1:0] ew,
    input  logic [CRC_DW-1:0]   data,
    input  logic                ref_in,
    input  logic                byte_rev,
    output logic [CRC_DW-1:0]   next_state
);
    localparam int WORD_W = NUM_BYTES * BYTE_W;

    logic [WIDTH_FW-1:0] up_sh;
    logic [CRC_DW-1:0]   top_poly;
    logic [WORD_W-1:0]   ordered;
    logic [CRC_DW-1:0]   chain [NUM_BYTES+1];

    // alignment shift that moves the state MSB to the top bit
    assign up_sh    = WIDTH_FW'(CRC_DW) - ew;
    assign top_poly = poly << up_sh;
    assign chain[0] = state << up_sh;

    // optional reversal of the byte order of the input word
    always_comb begin
        for (int b = 0; b < NUM_BYTES; b++) begin
            ordered[b*BYTE_W +: BYTE_W] = byte_rev ? data[(NUM_BYTES-1-b)*BYTE_W +: BYTE_W]
                                                   : data[b*BYTE_W +: BYTE_W];
        end
    end

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] raw_byte;
        logic [BYTE_W-1:0] in_byte;
        logic [CRC_DW-1:0] acc;

        assign raw_byte = ordered[g*BYTE_W +: BYTE_W];
        assign in_byte  = ref_in ? flip_byte(raw_byte) : raw_byte;

        // eight serial shift steps, MSB of the prepared byte first
        always_comb begin
            acc = chain[g];
            for (int j = BYTE_W - 1; j >= 0; j--) begin
                if (acc[CRC_DW-1] ^ in_byte[j]) acc = (acc << 1) ^ top_poly;
                else                            acc = acc << 1;
            end
        end

        assign chain[g+1] = acc;
    end

    assign next_state = chain[NUM_BYTES] >> up_sh;

endmodule

// File: rtl/crc_mc_channel.sv
// crc_mc_channel: settings, running state and read mux of one CRC channel.
// Assumes the parent has already checked word alignment and channel select;
// wr_en is the qualified write strobe and woff the word offset in the window.
module crc_mc_channel
    import crc_mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        woff,
    input  logic [CRC_DW-1:0] wdata,
    output logic [CRC_DW-1:0] rdata
);
    logic [7:0]          code_q;
    logic [CRC_DW-1:0]   poly_q;
    logic [CRC_DW-1:0]   start_q;
    logic [CRC_DW-1:0]   fxor_q;
    logic [WIDTH_FW-1:0] width_q;
    logic                refin_q;
    logic                refout_q;
    logic                brev_q;
    logic [CRC_DW-1:0]   data_q;
    logic [CRC_DW-1:0]   state_q;

    logic [WIDTH_FW-1:0] ew;
    logic [CRC_DW-1:0]   wmask;
    logic [CRC_DW-1:0]   fold_next;
    logic [CRC_DW-1:0]   result;
    logic [CRC_DW-1:0]   mode_word;
    crc_algo_t           cat;

    assign ew    = eff_width(width_q);
    assign wmask = width_mask(ew);
    assign cat   = code_lookup(wdata[7:0]);

    crc_word_folder #(.NUM_BYTES(CRC_DW / BYTE_W)) u_fold (
        .state      (state_q),
        .poly       (poly_q),
        .ew         (ew),
        .data       (wdata),
        .ref_in     (refin_q),
        .byte_rev   (brev_q),
        .next_state (fold_next)
    );

    // finished CRC: optional reflection within the width, then final XOR
    always_comb begin
        logic [CRC_DW-1:0] held;
        logic [CRC_DW-1:0] shown;
        held   = state_q & wmask;
        shown  = refout_q ? (flip_word(held) >> (WIDTH_FW'(CRC_DW) - ew)) : held;
        result = (shown ^ fxor_q) & wmask;
    end

    // packed image of the mode register
    always_comb begin
        mode_word                  = '0;
        mode_word[WIDTH_FW-1:0]    = width_q;
        mode_word[MODE_REFIN_BIT]  = refin_q;
        mode_word[MODE_REFOUT_BIT] = refout_q;
        mode_word[MODE_BREV_BIT]   = brev_q;
    end

    // register updates for every writable offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= '0;
            poly_q   <= '0;
            start_q  <= '0;
            fxor_q   <= '0;
            width_q  <= '0;
            refin_q  <= 1'b0;
            refout_q <= 1'b0;
            brev_q   <= 1'b0;
            data_q   <= '0;
            state_q  <= '0;
        end else if (wr_en) begin
            case (woff)
                WOFF_CODE: begin
                    code_q <= wdata[7:0];
                    if (code_known(wdata[7:0])) begin
                        poly_q   <= cat.poly;
                        start_q  <= cat.start;
                        fxor_q   <= cat.fxor;
                        width_q  <= cat.width;
                        refin_q  <= cat.ref_in;
                        refout_q <= cat.ref_out;
                        state_q  <= cat.start & width_mask(eff_width(cat.width));
                    end
                end
                WOFF_CLEAR: begin
                    if (wdata[0]) begin
                        code_q   <= '0;
                        poly_q   <= '0;
                        start_q  <= '0;
                        fxor_q   <= '0;
                        width_q  <= '0;
                        refin_q  <= 1'b0;
                        refout_q <= 1'b0;
                        brev_q   <= 1'b0;
                        data_q   <= '0;
                        state_q  <= '0;
                    end
                end
                WOFF_POLY:  poly_q <= wdata;
                WOFF_START: begin
                    start_q <= wdata;
                    state_q <= wdata & wmask;
                end
                WOFF_FXOR:  fxor_q <= wdata;
                WOFF_MODE: begin
                    width_q  <= wdata[WIDTH_FW-1:0];
                    refin_q  <= wdata[MODE_REFIN_BIT];
                    refout_q <= wdata[MODE_REFOUT_BIT];
                    brev_q   <= wdata[MODE_BREV_BIT];
                end
                WOFF_DATA: begin
                    data_q  <= wdata;
                    state_q <= fold_next;
                end
                WOFF_RESULT: state_q <= wdata & wmask;
                default: ;
            endcase
        end
    end

    // read mux over the channel window
    always_comb begin
        case (woff)
            WOFF_CODE:   rdata = {{(CRC_DW-8){1'b0}}, code_q};
            WOFF_POLY:   rdata = poly_q;
            WOFF_START:  rdata = start_q;
            WOFF_FXOR:   rdata = fxor_q;
            WOFF_MODE:   rdata = mode_word;
            WOFF_DATA:   rdata = data_q;
            WOFF_RESULT: rdata = result;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/crc_mc_engine.sv
// crc_mc_engine: top of the multi-channel CRC engine. Splits the byte address
// into channel select and window offset, qualifies writes and picks the read
// data of the addressed channel. Assumes ADDR_W = WIN_BITS + log2(NUM_CH).
module crc_mc_engine
    import crc_mc_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int WIN_BITS = 6,
    parameter int ADDR_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CRC_DW-1:0] reg_wdata,
    output logic [CRC_DW-1:0] reg_rdata
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [CH_W-1:0]     ch_sel;
    logic [3:0]          woff;
    logic                aligned;
    logic [CRC_DW-1:0]   ch_rdata [NUM_CH];

    assign ch_sel  = reg_addr[WIN_BITS +: CH_W];
    assign woff    = reg_addr[WIN_BITS-1:2];
    assign aligned = (reg_addr[1:0] == 2'b00);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic ch_wr;
        // write strobe qualified by alignment and channel select
        assign ch_wr = reg_wr && aligned && (ch_sel == CH_W'(c));

        crc_mc_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (ch_wr),
            .woff  (woff),
            .wdata (reg_wdata),
            .rdata (ch_rdata[c])
        );
    end

    // read data of the addressed channel, zero for a misaligned access
    always_comb begin
        reg_rdata = aligned ? ch_rdata[ch_sel] : '0;
    end

endmodule

// File: rtl/crc_mc_engine_chk.sv
// crc_mc_engine_chk: port-level properties of the CRC engine, bound to the
// top module. Assumes the default window layout (offset in address bits 5:0).
module crc_mc_engine_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata
);
    // R3
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[5:0] == 6'h04) |-> (reg_rdata == 32'h0));

    // R1
    reserved_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[5] == 1'b1) |-> (reg_rdata == 32'h0));

    // R4
    mode_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[5:0] == 6'h14) |-> ((reg_rdata & ~32'h0101013F) == 32'h0));

    // R2
    poly_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[5:0] == 6'h08) |=>
        ((reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata))));

    // R5
    code_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[5:0] == 6'h00) |=>
        ((reg_addr != $past(reg_addr)) || (reg_rdata == {24'h0, $past(reg_wdata[7:0])})));

endmodule

bind crc_mc_engine crc_mc_engine_chk #(.ADDR_W(ADDR_W)) u_crc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/crc_mc_engine_bench.sv
// crc_mc_engine_bench: behavioural model of all eight channels, compared with
// the read port in every cycle of the run.
module crc_mc_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    crc_mc_engine u_crc_mc_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // model state per channel
    logic [7:0]  m_code  [8];
    logic [31:0] m_poly  [8];
    logic [31:0] m_start [8];
    logic [31:0] m_fxor  [8];
    logic [5:0]  m_width [8];
    logic        m_ri    [8];
    logic        m_ro    [8];
    logic        m_br    [8];
    logic [31:0] m_data  [8];
    logic [31:0] m_state [8];

    function automatic int ew_of(input logic [5:0] w);
        return (w == 0 || w > 32) ? 32 : int'(w);
    endfunction

    function automatic logic [31:0] mask_of(input int ew);
        logic [63:0] one = 64'd1;
        return 32'((one << ew) - 1);
    endfunction

    function automatic void model_clear(input int c);
        m_code[c] = 0; m_poly[c] = 0; m_start[c] = 0; m_fxor[c] = 0;
        m_width[c] = 0; m_ri[c] = 0; m_ro[c] = 0; m_br[c] = 0;
        m_data[c] = 0; m_state[c] = 0;
    endfunction

    // serial LFSR over the bit stream of one word
    function automatic logic [31:0] model_fold(input int c, input logic [31:0] d);
        int ew = ew_of(m_width[c]);
        logic [31:0] m = mask_of(ew);
        logic [31:0] s = m_state[c] & m;
        logic [31:0] p = m_poly[c] & m;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] by = m_br[c] ? d[8*(3-k) +: 8] : d[8*k +: 8];
            for (int j = 0; j < 8; j++) begin
                logic bitv = m_ri[c] ? by[j] : by[7-j];
                logic fb = s[ew-1] ^ bitv;
                s = (s << 1) & m;
                if (fb) s = s ^ p;
            end
        end
        return s;
    endfunction

    function automatic logic [31:0] model_result(input int c);
        int ew = ew_of(m_width[c]);
        logic [31:0] m = mask_of(ew);
        logic [31:0] h = m_state[c] & m;
        logic [31:0] r = 0;
        if (m_ro[c]) begin
            for (int i = 0; i < ew; i++) r[i] = h[ew-1-i];
        end else r = h;
        return (r ^ m_fxor[c]) & m;
    endfunction

    function automatic logic [31:0] model_read(input logic [8:0] a);
        int c = int'(a[8:6]);
        if (a[1:0] != 0) return 0;
        case (a[5:2])
            0: return {24'h0, m_code[c]};
            2: return m_poly[c];
            3: return m_start[c];
            4: return m_fxor[c];
            5: return {7'h0, m_br[c], 7'h0, m_ro[c], 7'h0, m_ri[c], 2'b0, m_width[c]};
            6: return m_data[c];
            7: return model_result(c);
            default: return 0;
        endcase
    endfunction

    function automatic void apply_code(input int c, input logic [7:0] code);
        logic [31:0] p, s, x; int w; logic r;
        case (code)
            1:  begin p = 32'h04C11DB7; s = 32'hFFFFFFFF; x = 32'hFFFFFFFF; w = 32; r = 1; end
            2:  begin p = 32'hF4ACFB13; s = 32'hFFFFFFFF; x = 32'hFFFFFFFF; w = 32; r = 1; end
            3:  begin p = 32'h1021; s = 0;       x = 0;       w = 16; r = 1; end
            4:  begin p = 32'h1021; s = 0;       x = 0;       w = 16; r = 0; end
            5:  begin p = 32'h8005; s = 32'hFFFF; x = 0;       w = 16; r = 1; end
            6:  begin p = 32'h3D65; s = 0;       x = 32'hFFFF; w = 16; r = 1; end
            7:  begin p = 32'h1021; s = 32'hFFFF; x = 32'hFFFF; w = 16; r = 1; end
            8:  begin p = 32'h8005; s = 32'hFFFF; x = 32'hFFFF; w = 16; r = 1; end
            9:  begin p = 32'h8005; s = 0;       x = 32'hFFFF; w = 16; r = 1; end
            10: begin p = 32'h8005; s = 0;       x = 0;       w = 16; r = 1; end
            11: begin p = 32'h31;   s = 0;       x = 0;       w = 8;  r = 1; end
            12: begin p = 32'h07;   s = 32'hFF;  x = 0;       w = 8;  r = 1; end
            13: begin p = 32'h07;   s = 0;       x = 32'h55;  w = 8;  r = 0; end
            14: begin p = 32'h07;   s = 0;       x = 0;       w = 8;  r = 0; end
            default: begin p = 32'h05; s = 32'h1F; x = 32'h1F; w = 5; r = 1; end
        endcase
        m_poly[c] = p; m_start[c] = s; m_fxor[c] = x; m_width[c] = 6'(w);
        m_ri[c] = r; m_ro[c] = r; m_state[c] = s & mask_of(w);
    endfunction

    function automatic void model_write(input logic [8:0] a, input logic [31:0] d);
        int c = int'(a[8:6]);
        if (a[1:0] != 0) return;
        case (a[5:2])
            0: begin m_code[c] = d[7:0]; if (d[7:0] >= 1 && d[7:0] <= 15) apply_code(c, d[7:0]); end
            1: if (d[0]) model_clear(c);
            2: m_poly[c] = d;
            3: begin m_start[c] = d; m_state[c] = d & mask_of(ew_of(m_width[c])); end
            4: m_fxor[c] = d;
            5: begin m_width[c] = d[5:0]; m_ri[c] = d[8]; m_ro[c] = d[16]; m_br[c] = d[24]; end
            6: begin m_state[c] = model_fold(c, d); m_data[c] = d; end
            7: m_state[c] = d & mask_of(ew_of(m_width[c]));
            default: ;
        endcase
    endfunction

    // one bus cycle: drive, compare read port, then update model after the edge
    task automatic step(input logic we, input logic [8:0] a, input logic [31:0] d, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        reg_wr = we; reg_addr = a; reg_wdata = d;
        #2;
        exp = model_read(a);
        total++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%03h actual=%08h expected=%08h", tag, a, reg_rdata, exp);
        end
        @(posedge clk);
        #1;
        if (we && rst_n) model_write(a, d);
    endtask

    task automatic wr(input int c, input int off, input logic [31:0] d, input string tag);
        step(1'b1, 9'(c * 64 + off), d, tag);
    endtask

    task automatic rd(input int c, input int off, input string tag);
        step(1'b0, 9'(c * 64 + off), 32'h0, tag);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) model_clear(c);
        repeat (3) @(posedge clk);
        // R11: registers read zero after reset
        rd(0, 8, "R11"); rd(7, 'h14, "R11"); rd(3, 'h1C, "R11");
        rst_n = 1'b1;

        // R2: full-width readback
        wr(3, 'h08, 32'hDEADBEEF, "R2"); rd(3, 'h08, "R2");
        wr(3, 'h0C, 32'h12345678, "R2"); rd(3, 'h0C, "R2");
        wr(3, 'h10, 32'hA5A5A5A5, "R2"); rd(3, 'h10, "R2");
        // R1: reserved and misaligned accesses
        wr(3, 'h24, 32'hFFFFFFFF, "R1"); rd(3, 'h24, "R1");
        wr(3, 'h0A, 32'h0, "R1"); rd(3, 'h08, "R1"); rd(3, 'h0A, "R1");
        // R4: mode fields and spare bits
        wr(2, 'h14, 32'hFFFFFFFF, "R4"); rd(2, 'h14, "R4");
        // R5: every catalogue entry, with and without byte reversal
        for (int code = 1; code <= 15; code++) begin
            int c = code % 8;
            wr(c, 'h14, (code % 2) ? 32'h01000000 : 32'h0, "R5");
            wr(c, 'h00, 32'(code), "R5");
            rd(c, 'h00, "R5"); rd(c, 'h08, "R5"); rd(c, 'h14, "R5"); rd(c, 'h1C, "R5");
            wr(c, 'h18, 32'h34333231, "R6"); wr(c, 'h18, 32'h38373635, "R6");
            rd(c, 'h1C, "R7"); rd(c, 'h18, "R2");
        end
        // R5: unknown codes leave settings alone
        wr(4, 'h00, 32'h00000014, "R5"); rd(4, 'h08, "R5"); rd(4, 'h00, "R5");
        wr(4, 'h00, 32'h0, "R5"); rd(4, 'h0C, "R5");
        // R6/R7: custom 12-bit, all ordering mixes
        for (int mode = 0; mode < 8; mode++) begin
            wr(5, 'h14, {7'h0, 1'(mode >> 2), 7'h0, 1'(mode >> 1), 7'h0, 1'(mode), 2'b0, 6'd12}, "R6");
            wr(5, 'h08, 32'h0000080F, "R6");
            wr(5, 'h10, 32'hFFFFF0F0, "R7");
            wr(5, 'h0C, 32'h00000ABC, "R8");
            wr(5, 'h18, 32'hC0FFEE01, "R6");
            rd(5, 'h1C, "R7");
        end
        // R9: width 0 and width 40 behave as 32
        wr(6, 'h08, 32'h04C11DB7, "R9");
        wr(6, 'h14, 32'h00000000, "R9"); wr(6, 'h0C, 32'hFFFFFFFF, "R9");
        wr(6, 'h18, 32'h11223344, "R9"); rd(6, 'h1C, "R9");
        wr(6, 'h14, 32'h00000028, "R9"); wr(6, 'h18, 32'h55667788, "R9"); rd(6, 'h1C, "R9");
        // R8: direct result write, masked to width
        wr(1, 'h00, 32'd14, "R8"); wr(1, 'h1C, 32'h0000ABCD, "R8"); rd(1, 'h1C, "R8");
        // R3: clear with bit 0 low, then high
        wr(1, 'h04, 32'hFFFFFFFE, "R3"); rd(1, 'h08, "R3"); rd(1, 'h04, "R3");
        wr(1, 'h04, 32'h00000001, "R3"); rd(1, 'h08, "R3"); rd(1, 'h14, "R3"); rd(1, 'h1C, "R3");
        // R10: traffic on one channel, others read back unchanged
        wr(0, 'h00, 32'd1, "R10");
        for (int k = 0; k < 6; k++) wr(0, 'h18, 32'h01020304 * 32'(k + 1), "R10");
        for (int c = 1; c < 8; c++) begin
            rd(c, 'h1C, "R10"); rd(c, 'h08, "R10");
        end
        // mixed traffic across all channels
        for (int n = 0; n < 600; n++) begin
            int c = int'($urandom_range(0, 7));
            int sel = int'($urandom_range(0, 15));
            logic [31:0] d = $urandom;
            case (sel)
                0: wr(c, 'h00, 32'($urandom_range(0, 20)), "R5");
                1: wr(c, 'h04, d, "R3");
                2: wr(c, 'h08, d, "R2");
                3: wr(c, 'h0C, d, "R8");
                4: wr(c, 'h10, d, "R7");
                5: wr(c, 'h14, d, "R4");
                6, 7, 8, 9: wr(c, 'h18, d, "R6");
                10: wr(c, 'h1C, d, "R8");
                11: wr(c, 'h20 + 4 * int'($urandom_range(0, 7)), d, "R1");
                default: rd(c, 4 * int'($urandom_range(0, 15)), "R10");
            endcase
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule